// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable model of a byte-wide serial EEPROM that sits on a two-wire (I2C-style) bus as a target. It samples SCL and SDA with the system clock and detects bus edges from the sampled levels. It drives SDA only through an open-drain pull-down enable. The storage array is 4096 x 8 by default, or 8192 x 8 with `ADDR_W = 13`. It is divided into 32-byte pages.

A host opens a transfer with a start condition and then sends a select byte. The select byte carries a fixed device code, the three strap bits and a read/write flag. For a write, two word-address bytes follow and then data bytes. Those data bytes are collected in a page buffer. They reach the array only after the stop condition, during a timed internal write interval. While that interval runs, the target refuses its select byte, so a host can poll for completion.

For a read, the target sends bytes from the current address. The host acknowledges each byte to get the next one and ends the read with a no-acknowledge followed by a stop. A random read is done by setting the address with a write that carries no data, then issuing a repeated start with a read select. A write-protect input guards the upper quarter of the array.

Top module: `seeprom_target`

## Requirements
- R1: A falling SDA while SCL is high is a start and a rising SDA while SCL is high is a stop. After a stop the target returns to idle and does not pull SDA low.
- R2: The select byte is sent MSB first. Bits 7:4 are 1010, bits 3:1 must equal `strap_i[2:0]`, and bit 0 is 1 for a read. A matching select is acknowledged by pulling SDA low during the ninth clock. A non-matching select gets no acknowledge.
- R3: After a write select, two address bytes follow, high byte first. Each is acknowledged. Bits of the high byte above `ADDR_W-8` are ignored.
- R4: After a stop, a data byte written to an address can be read back from that address.
- R5: In a write, the address advances only in its low 5 bits and wraps inside the 32-byte page. Bytes of the page that were not sent keep their previous contents.
- R6: When `wp_i` is high, writes to addresses whose two top bits are 11 leave the array unchanged, but their data bytes are still acknowledged. Writes below that quarter, and all writes while `wp_i` is low, take effect.
- R7: A stop that ends a write carrying at least one data byte starts a busy interval of `max(WR_CYCLES, 32)` clocks. During that interval no select byte is acknowledged. A write that carries no data starts no busy interval.
- R8: Read data is sent MSB first. The target changes SDA only while SCL is low.
- R9: In a read, a host acknowledge requests the next byte. The read address advances across page boundaries and rolls over from the last location to 0.
- R10: After a host no-acknowledge, the target stops driving SDA. A later read with no address phase continues from the address that follows the last byte sent.
- R11: During and after reset, the target does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus (wired-AND line) |
| strap_i | input | 3 | Device address straps compared with select bits 3:1 |
| wp_i | input | 1 | Write protect for the upper quarter of the array |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |

## Verification
The stimulus varies the select byte in three ways: a wrong strap value, a wrong device code, and a correct one. This shows that both fields take part in the match. A page write that starts four bytes before the end of a page, into a page whose other bytes were set beforehand, separates a correct low-bit wrap from a full-address carry and from a whole-page overwrite. Reads that cross a page edge and the top of the array show that the read counter uses every address bit. Protected writes on both sides of the quarter boundary, and polling right after a stop, confirm where protection applies and how long the busy interval lasts.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    localparam int          STRAP_W  = 3;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_SACK,
        ST_MACK
    } bus_st_e;

endpackage

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev_q;

    assign raw = {scl_raw, sda_raw};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
            end
            assign lvl[g] = pipe_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign scl_lvl  = lvl[1];
    assign sda_lvl  = lvl[0];
    assign scl_rise =  lvl[1] & ~prev_q[1];
    assign scl_fall = ~lvl[1] &  prev_q[1];
    assign start_ev =  lvl[1] &  prev_q[1] &  prev_q[0] & ~lvl[0];
    assign stop_ev  =  lvl[1] &  prev_q[1] & ~prev_q[0] &  lvl[0];

endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
    import seeprom_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wp,
    input  logic [7:0]         rd_data,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [7:0]         mem_wdata,
    output logic               sda_oe,
    output logic               busy
);

    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int PG_W     = ADDR_W - OFF_W;
    localparam int HI_W     = ADDR_W - 8;
    localparam int BUSY_LEN = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;
    localparam int CNT_W    = $clog2(BUSY_LEN + 1);
    localparam logic [OFF_W:0] CIDX_END = (OFF_W + 1)'(PAGE_BYTES);

    typedef struct packed {
        bus_st_e                      st;
        bus_st_e                      nxt;
        logic [3:0]                   bcnt;
        logic [7:0]                   sh;
        logic [7:0]                   tx;
        logic [HI_W-1:0]              ahi;
        logic [ADDR_W-1:0]            addr;
        logic                         oe;
        logic                         mack;
        logic                         wpend;
        logic [PG_W-1:0]              pg;
        logic [PAGE_BYTES-1:0]        mask;
        logic [PAGE_BYTES-1:0][7:0]   pbuf;
        logic                         busy;
        logic [CNT_W-1:0]             bleft;
        logic [OFF_W:0]               cidx;
    } ctl_t;

    ctl_t q, d;

    logic [OFF_W-1:0]      off;
    logic [PAGE_BYTES-1:0] msk;
    logic                  allow;
    logic                  sel_hit;

    always_comb begin
        d       = q;
        off     = q.addr[OFF_W-1:0];
        msk     = q.wpend ? q.mask : '0;
        allow   = !(wp && (q.addr[ADDR_W-1 -: 2] == 2'b11));
        sel_hit = (q.sh[7:4] == DEV_CODE) && (q.sh[3:1] == strap) && !q.busy;

        // timed commit of the page buffer, one byte per clock
        if (q.busy) begin
            if (q.cidx != CIDX_END) d.cidx = q.cidx + 1'b1;
            if (q.bleft == CNT_W'(1)) begin
                d.busy  = 1'b0;
                d.bleft = '0;
            end else begin
                d.bleft = q.bleft - 1'b1;
            end
        end

        if (start_ev) begin
            d.st    = ST_SEL;
            d.bcnt  = '0;
            d.oe    = 1'b0;
            d.wpend = 1'b0;
        end else if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
            if (q.wpend) begin
                d.wpend = 1'b0;
                d.busy  = 1'b1;
                d.bleft = CNT_W'(BUSY_LEN);
                d.cidx  = '0;
            end
        end else begin
            unique case (q.st)
                ST_SEL, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && (q.bcnt < 4'd8)) begin
                        d.sh   = {q.sh[6:0], sda_lvl};
                        d.bcnt = q.bcnt + 1'b1;
                    end
                    if (scl_fall && (q.bcnt == 4'd8)) begin
                        d.oe = 1'b1;
                        d.st = ST_SACK;
                        unique case (q.st)
                            ST_SEL: begin
                                if (sel_hit) begin
                                    d.nxt = q.sh[0] ? ST_RDAT : ST_AHI;
                                end else begin
                                    d.oe = 1'b0;
                                    d.st = ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                d.ahi = q.sh[HI_W-1:0];
                                d.nxt = ST_ALO;
                            end
                            ST_ALO: begin
                                d.addr = {q.ahi, q.sh};
                                d.nxt  = ST_WDAT;
                            end
                            default: begin
                                if (!q.wpend) d.pg = q.addr[ADDR_W-1:OFF_W];
                                d.pbuf[off] = q.sh;
                                if (allow) msk[off] = 1'b1;
                                d.mask  = msk;
                                d.wpend = 1'b1;
                                d.addr[OFF_W-1:0] = off + 1'b1;
                                d.nxt   = ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_SACK: begin
                    if (scl_fall) begin
                        d.bcnt = '0;
                        if (q.nxt == ST_RDAT) begin
                            d.oe   = ~rd_data[7];
                            d.tx   = {rd_data[6:0], 1'b0};
                            d.bcnt = 4'd1;
                            d.addr = q.addr + 1'b1;
                            d.st   = ST_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            d.st = q.nxt;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (q.bcnt < 4'd8) begin
                            d.oe   = ~q.tx[7];
                            d.tx   = {q.tx[6:0], 1'b0};
                            d.bcnt = q.bcnt + 1'b1;
                        end else begin
                            d.oe   = 1'b0;
                            d.mack = 1'b0;
                            d.st   = ST_MACK;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) d.mack = ~sda_lvl;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.oe   = ~rd_data[7];
                            d.tx   = {rd_data[6:0], 1'b0};
                            d.bcnt = 4'd1;
                            d.addr = q.addr + 1'b1;
                            d.st   = ST_RDAT;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe    = q.oe;
    assign busy      = q.busy;
    assign rd_addr   = q.addr;
    assign mem_we    = q.busy && (q.cidx != CIDX_END) && q.mask[q.cidx[OFF_W-1:0]];
    assign mem_waddr = {q.pg, q.cidx[OFF_W-1:0]};
    assign mem_wdata = q.pbuf[q.cidx[OFF_W-1:0]];

endmodule

// File: rtl/seeprom_target.sv
module seeprom_target
    import seeprom_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_BYTES  = 32,
    parameter int WR_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wp_i,
    output logic               sda_oe_o
);

    localparam int BUSY_LEN = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic              mem_we, sda_oe, busy;
    logic [ADDR_W-1:0] rd_addr, mem_waddr;
    logic [7:0]        rd_data, mem_wdata;

    seeprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    seeprom_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .WR_CYCLES  (WR_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .strap     (strap_i),
        .wp        (wp_i),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe),
        .busy      (busy)
    );

    seeprom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign sda_oe_o = sda_oe;

endmodule

// File: rtl/seeprom_target_chk.sv
module seeprom_target_chk #(
    parameter int BUSY_LEN = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic stop_ev,
    input logic sda_oe,
    input logic busy
);

    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R8: the pull-down changes only while the sampled clock is low
    assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // R1: a stop leaves the line released
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R7: no acknowledge is started while the internal write runs
    assert_busy_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(busy));

    // R7: busy interval has the configured length
    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == BUSY_LEN));

    // R7: busy only begins at a stop
    assert_busy_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_ev));

endmodule

bind seeprom_target seeprom_target_chk #(.BUSY_LEN(BUSY_LEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (scl_lvl),
    .stop_ev (stop_ev),
    .sda_oe  (sda_oe),
    .busy    (busy)
);

// File: tb/seeprom_target_bench.sv
module seeprom_target_bench;

    localparam int HALF  = 8;
    localparam int AW    = 12;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic       line;

    assign line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    seeprom_target u_seeprom_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (line),
        .strap_i  (strap),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    int          total = 0;
    int          bad = 0;
    bit          finished = 0;
    logic [7:0]  model [int];
    logic [7:0]  exp_q [$];
    logic [7:0]  act_q [$];
    string       req_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] sel(input bit rd, input logic [2:0] s);
        return {4'b1010, s, rd};
    endfunction

    task automatic bstart();
        wt(2); sda_m = 1'b1; wt(HALF); scl = 1'b1; wt(HALF); sda_m = 1'b0; wt(HALF); scl = 1'b0;
    endtask

    task automatic bstop();
        wt(2); sda_m = 1'b0; wt(HALF); scl = 1'b1; wt(HALF); sda_m = 1'b1; wt(HALF);
    endtask

    task automatic sbit(input bit b);
        wt(2); sda_m = b; wt(HALF - 2); scl = 1'b1; wt(HALF); scl = 1'b0;
    endtask

    task automatic gbit(output bit b);
        wt(2); sda_m = 1'b1; wt(HALF - 2); scl = 1'b1; wt(HALF / 2); b = line; wt(HALF / 2); scl = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) sbit(v[i]);
        gbit(a);
        ack = (a == 1'b0);
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            gbit(b);
            v[i] = b;
        end
        sbit(give_ack ? 1'b0 : 1'b1);
    endtask

    task automatic wait_ready(output int nacks);
        bit ak;
        nacks = 0;
        for (int k = 0; k < 40; k++) begin
            bstart();
            wbyte(sel(1'b0, strap), ak);
            bstop();
            if (ak) break;
            nacks++;
        end
    endtask

    task automatic set_addr(input int a, input logic [7:0] junk);
        bit ak;
        bstart();
        wbyte(sel(1'b0, strap), ak);
        chk(ak, "R2 select ack", ak, 1);
        wbyte(junk | 8'(a >> 8), ak);
        chk(ak, "R3 high address ack", ak, 1);
        wbyte(8'(a), ak);
        chk(ak, "R3 low address ack", ak, 1);
    endtask

    task automatic do_write(input int a, input logic [7:0] dat [$], input logic [7:0] junk, input string req);
        bit ak;
        int n;
        int aa;
        set_addr(a, junk);
        foreach (dat[i]) begin
            wbyte(dat[i], ak);
            chk(ak, {req, " data ack"}, ak, 1);
            aa = (a & ~31) | ((a + i) & 31);
            if (!(wp && aa >= 12'hC00)) model[aa] = dat[i];
        end
        bstop();
        wait_ready(n);
        chk(n > 0 && n < 40, "R7 busy polls after write", n, 1);
    endtask

    task automatic do_read(input int a, input int n, input string req);
        bit ak;
        bit rel;
        logic [7:0] v;
        set_addr(a, 8'h00);
        bstart();
        wbyte(sel(1'b1, strap), ak);
        chk(ak, "R2 read select ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i < n - 1, v);
            exp_q.push_back(model[(a + i) % DEPTH]);
            act_q.push_back(v);
            req_q.push_back(req);
        end
        gbit(rel);
        chk(rel == 1'b1, "R10 line released after nack", rel, 1);
        bstop();
    endtask

    // monitor: compares returned read bytes against expectations
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                logic [7:0] a;
                logic [7:0] e;
                string r;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(a === e, r, a, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ak;
        int n;
        logic [7:0] v;

        wt(5);
        chk(sda_oe == 1'b0, "R11 released in reset", sda_oe, 0);
        wt(15);
        rst_n = 1'b1;
        wt(10);
        chk(sda_oe == 1'b0 && line == 1'b1, "R11 released after reset", sda_oe, 0);

        // R2: wrong strap and wrong device code
        bstart(); wbyte(sel(1'b0, 3'b000), ak); bstop();
        chk(!ak, "R2 wrong strap nack", ak, 0);
        bstart(); wbyte({4'b1011, strap, 1'b0}, ak); bstop();
        chk(!ak, "R2 wrong code nack", ak, 0);

        // R4 / R3: byte write with junk in ignored high bits
        do_write(12'h123, '{8'h5A}, 8'hF0, "R4");
        do_read(12'h123, 1, "R4 byte readback");

        // R7: address-only write starts no busy interval
        set_addr(12'h123, 8'h00);
        bstop();
        bstart(); wbyte(sel(1'b0, strap), ak); bstop();
        chk(ak, "R7 no busy after dataless write", ak, 1);

        // R5: partial page write wrapping inside page 1
        do_write(12'h022, '{8'h77}, 8'h00, "R5");
        do_write(12'h040, '{8'hC1, 8'hC2}, 8'h00, "R5");
        do_write(12'h03C, '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15}, 8'h00, "R5");
        do_read(12'h03C, 4, "R5 page tail");
        do_read(12'h020, 3, "R5 wrapped head and untouched byte");
        do_read(12'h03E, 4, "R9 read crosses page");

        // R6: protection at the quarter boundary
        do_write(12'hC00, '{8'h55}, 8'h00, "R6");
        do_write(12'hBFF, '{8'h20}, 8'h00, "R6");
        wp = 1'b1;
        do_write(12'hC00, '{8'hEE}, 8'h00, "R6 protected");
        do_write(12'hBFF, '{8'h44}, 8'h00, "R6 unprotected");
        do_read(12'hBFF, 2, "R6 boundary readback");
        wp = 1'b0;

        // R9 / R10: rollover and continuation
        do_write(12'hFFF, '{8'hA5}, 8'h00, "R9");
        do_write(12'h000, '{8'h3C, 8'h3D}, 8'h00, "R9");
        do_read(12'hFFF, 2, "R9 rollover");
        bstart();
        wbyte(sel(1'b1, strap), ak);
        chk(ak, "R10 current read select ack", ak, 1);
        rbyte(1'b0, v);
        exp_q.push_back(model[1]);
        act_q.push_back(v);
        req_q.push_back("R10 continue after nack");
        bstop();

        wt(50);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule